// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block steers a chip through six operating modes of increasing depth: run, wait, doze, state retention, deep sleep and hibernate. Software selects a target mode by presenting a mode code with a request strobe while the chip is running. The controller then drives the gating pattern for that mode. The pattern covers the core clock, the bus clock, a set of per-peripheral clocks, the PLL enable, the external-memory self-refresh request, the core power enable and a whole-chip power-down request.

An interrupt brings the chip back to run from the shallow modes within one clock. From the two retention-style modes the wake is staged. Core power and the PLL come back first. A relock wait follows, in which a lock indication counts only after a minimum settling window. Self-refresh is then cleared while the clocks are still held off, and only after that do the clocks run. Hibernate is left only through system reset, which the surrounding system asserts on an external wake.

A mode status output always shows the mode the controller has actually reached. While a wake is in progress it still shows the sleep mode being left.

Top module: `lpm_ctrl`

## Requirements
- R1: While reset is low and after its release, the block is in run (status code 0): all clock enables are 1, PLL enable is 1, core power enable is 1, self-refresh request is 0, chip power-down request is 0, and the peripheral mask is all zeros.
- R2: Mode codes are run 0, wait 1, doze 2, retention 3, deep sleep 4, hibernate 5. A request is taken only in run and only with a code from 1 to 5. Codes 0, 6 and 7, and any request made outside run, leave the mode unchanged.
- R3: In wait, only the core clock enable is 0. The bus clock, the peripheral clocks, the PLL and core power stay on.
- R4: In doze, the core and bus clock enables are 0, and peripheral clock i is 0 exactly where mask bit i is 1. The mask register is loaded by a mask write only in run; a write in any other mode is ignored.
- R5: In retention, all clock enables and the PLL enable are 0, self-refresh is requested and core power stays on.
- R6: Deep sleep matches retention except that core power enable is 0.
- R7: An interrupt in wait or doze returns the block to run on the clock edge that samples it. An interrupt in run has no effect.
- R8: An interrupt in retention or deep sleep starts a wake. From the next cycle, PLL enable and core power enable are 1 while the clocks stay gated and self-refresh stays requested. PLL lock is accepted only after RELOCK_MIN cycles of that wait. The cycle after lock is accepted has self-refresh cleared and clocks still gated. The block reaches run on the following edge.
- R9: In hibernate, the chip power-down request is 1 and every other enable and request is 0. Interrupts and requests are ignored, and only reset leaves the mode.
- R10: The status output changes only when a mode is reached, and run is reported only together with the full run output pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Synchronous active-low reset, also the hibernate exit |
| req_valid | input | 1 | Mode request strobe |
| req_mode | input | 3 | Requested mode code |
| mask_wr | input | 1 | Load strobe for the peripheral gating mask |
| mask_in | input | N_PERIPH | Mask value; a 1 gates that peripheral in doze |
| irq | input | 1 | Wake interrupt |
| pll_locked | input | 1 | PLL lock indication |
| core_clk_en | output | 1 | Core clock enable |
| bus_clk_en | output | 1 | Bus clock enable |
| periph_clk_en | output | N_PERIPH | Per-peripheral clock enables |
| pll_en | output | 1 | PLL enable |
| mem_sr_req | output | 1 | External memory self-refresh request |
| core_pwr_en | output | 1 | Core power domain enable |
| chip_pdn_req | output | 1 | Whole-chip power-down request |
| cur_mode | output | 3 | Mode actually reached |

## Verification
The bench holds PLL lock low through a retention wake to show that the clocks stay gated. A controller that trusted the wake interrupt alone would release the clocks into an unlocked PLL. In deep sleep it leaves lock high the whole time, to mimic a stale indication. A design that ignored the settling window would reach run before RELOCK_MIN cycles had passed, and one that skipped the separate self-refresh exit step would run clocks while memory still refreshed itself. It also writes the mask during doze and sends requests from non-run modes and in hibernate. A wrong design would show a changed gating pattern on the next doze, hop between sleep modes, or wake from hibernate on an interrupt.

// File: rtl/lpm_pkg.sv
// Shared types for the low-power mode controller.
// Assumes mode codes 1..5 are the software request encoding.
package lpm_pkg;

    typedef enum logic [2:0] {
        MODE_RUN    = 3'd0,
        MODE_WAIT   = 3'd1,
        MODE_DOZE   = 3'd2,
        MODE_RETAIN = 3'd3,
        MODE_DSLEEP = 3'd4,
        MODE_HIBER  = 3'd5
    } lpm_mode_e;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_WAIT,
        ST_DOZE,
        ST_RETAIN,
        ST_DSLEEP,
        ST_HIBER,
        ST_RELOCK,
        ST_SREXIT
    } lpm_state_e;

    typedef struct packed {
        logic core_clk;
        logic bus_clk;
        logic periph_all;
        logic periph_masked;
        logic pll;
        logic self_ref;
        logic core_pwr;
        logic chip_pdn;
    } lpm_ctl_s;

endpackage

// File: rtl/lpm_req_filter.sv
// Request qualifier and peripheral mask register.
// Does: accepts a mode request only in run with a legal code; loads the
// doze gating mask only in run. Assumes synchronous active-low reset.
module lpm_req_filter
    import lpm_pkg::*;
#(
    parameter int N_PERIPH = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_run,
    input  logic                req_valid,
    input  logic [2:0]          req_mode,
    input  logic                mask_wr,
    input  logic [N_PERIPH-1:0] mask_in,
    output logic                accept,
    output lpm_mode_e           accept_mode,
    output logic [N_PERIPH-1:0] mask_q
);

    logic code_ok;

    // Legal target codes are wait through hibernate.
    always_comb begin
        code_ok     = (req_mode >= 3'd1) && (req_mode <= 3'd5);
        accept      = req_valid && in_run && code_ok;
        accept_mode = lpm_mode_e'(req_mode);
    end

    // Mask register, writable only while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (mask_wr && in_run) begin
            mask_q <= mask_in;
        end
    end

endmodule

// File: rtl/lpm_relock_timer.sv
// PLL relock qualifier.
// Does: counts cycles while a wake is waiting for the PLL and reports ready
// only once RELOCK_MIN cycles have elapsed and lock is seen.
// Assumes RELOCK_MIN >= 1; the count restarts whenever active drops.
module lpm_relock_timer #(
    parameter int RELOCK_MIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic pll_locked,
    output logic ready
);

    localparam int CW = $clog2(RELOCK_MIN + 1);
    localparam logic [CW-1:0] LIM = RELOCK_MIN[CW-1:0];

    logic [CW-1:0] cnt_q;

    // Saturating settle counter, cleared outside the relock wait.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            cnt_q <= '0;
        end else if (cnt_q != LIM) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Lock counts only after the settle window.
    always_comb begin
        ready = active && (cnt_q == LIM) && pll_locked;
    end

endmodule

// File: rtl/lpm_gate_decode.sv
// Output pattern decoder.
// Does: maps the controller state to the gating, PLL, self-refresh and
// power outputs; applies the mask per peripheral in doze.
// Assumes the state input is registered, so outputs are glitch-free.
module lpm_gate_decode
    import lpm_pkg::*;
#(
    parameter int N_PERIPH = 8
) (
    input  lpm_state_e          state,
    input  logic [N_PERIPH-1:0] mask,
    output logic                core_clk_en,
    output logic                bus_clk_en,
    output logic [N_PERIPH-1:0] periph_clk_en,
    output logic                pll_en,
    output logic                mem_sr_req,
    output logic                core_pwr_en,
    output logic                chip_pdn_req
);

    lpm_ctl_s ctl;

    // Per-state control pattern.
    always_comb begin
        ctl = '0;
        unique case (state)
            ST_RUN:    ctl = '{core_clk:1'b1, bus_clk:1'b1, periph_all:1'b1, periph_masked:1'b0,
                               pll:1'b1, self_ref:1'b0, core_pwr:1'b1, chip_pdn:1'b0};
            ST_WAIT:   ctl = '{core_clk:1'b0, bus_clk:1'b1, periph_all:1'b1, periph_masked:1'b0,
                               pll:1'b1, self_ref:1'b0, core_pwr:1'b1, chip_pdn:1'b0};
            ST_DOZE:   ctl = '{core_clk:1'b0, bus_clk:1'b0, periph_all:1'b0, periph_masked:1'b1,
                               pll:1'b1, self_ref:1'b0, core_pwr:1'b1, chip_pdn:1'b0};
            ST_RETAIN: ctl = '{core_clk:1'b0, bus_clk:1'b0, periph_all:1'b0, periph_masked:1'b0,
                               pll:1'b0, self_ref:1'b1, core_pwr:1'b1, chip_pdn:1'b0};
            ST_DSLEEP: ctl = '{core_clk:1'b0, bus_clk:1'b0, periph_all:1'b0, periph_masked:1'b0,
                               pll:1'b0, self_ref:1'b1, core_pwr:1'b0, chip_pdn:1'b0};
            ST_HIBER:  ctl = '{core_clk:1'b0, bus_clk:1'b0, periph_all:1'b0, periph_masked:1'b0,
                               pll:1'b0, self_ref:1'b0, core_pwr:1'b0, chip_pdn:1'b1};
            ST_RELOCK: ctl = '{core_clk:1'b0, bus_clk:1'b0, periph_all:1'b0, periph_masked:1'b0,
                               pll:1'b1, self_ref:1'b1, core_pwr:1'b1, chip_pdn:1'b0};
            ST_SREXIT: ctl = '{core_clk:1'b0, bus_clk:1'b0, periph_all:1'b0, periph_masked:1'b0,
                               pll:1'b1, self_ref:1'b0, core_pwr:1'b1, chip_pdn:1'b0};
            default:   ctl = '0;
        endcase
    end

    // Scalar outputs straight from the pattern.
    always_comb begin
        core_clk_en  = ctl.core_clk;
        bus_clk_en   = ctl.bus_clk;
        pll_en       = ctl.pll;
        mem_sr_req   = ctl.self_ref;
        core_pwr_en  = ctl.core_pwr;
        chip_pdn_req = ctl.chip_pdn;
    end

    // One enable per peripheral: on in full-run patterns, masked in doze.
    for (genvar i = 0; i < N_PERIPH; i++) begin : g_periph
        assign periph_clk_en[i] = ctl.periph_all | (ctl.periph_masked & ~mask[i]);
    end

endmodule

// File: rtl/lpm_ctrl.sv
// Low-power mode controller top.
// Does: sequences run/wait/doze/retention/deep-sleep/hibernate, staging
// the wake from the retention modes through PLL relock and self-refresh
// exit. Assumes synchronous active-low reset, which is also the only way
// out of hibernate.
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int N_PERIPH   = 8,
    parameter int RELOCK_MIN = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [2:0]          req_mode,
    input  logic                mask_wr,
    input  logic [N_PERIPH-1:0] mask_in,
    input  logic                irq,
    input  logic                pll_locked,
    output logic                core_clk_en,
    output logic                bus_clk_en,
    output logic [N_PERIPH-1:0] periph_clk_en,
    output logic                pll_en,
    output logic                mem_sr_req,
    output logic                core_pwr_en,
    output logic                chip_pdn_req,
    output logic [2:0]          cur_mode
);

    lpm_state_e          state_q, state_d;
    lpm_mode_e           mode_q, mode_d;
    logic                accept;
    lpm_mode_e           accept_mode;
    logic [N_PERIPH-1:0] mask_q;
    logic                relock_ready;

    lpm_req_filter #(.N_PERIPH(N_PERIPH)) u_req (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_run      (state_q == ST_RUN),
        .req_valid   (req_valid),
        .req_mode    (req_mode),
        .mask_wr     (mask_wr),
        .mask_in     (mask_in),
        .accept      (accept),
        .accept_mode (accept_mode),
        .mask_q      (mask_q)
    );

    lpm_relock_timer #(.RELOCK_MIN(RELOCK_MIN)) u_relock (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (state_q == ST_RELOCK),
        .pll_locked (pll_locked),
        .ready      (relock_ready)
    );

    // Next state and reached-mode update.
    always_comb begin
        state_d = state_q;
        mode_d  = mode_q;
        unique case (state_q)
            ST_RUN: begin
                if (accept) begin
                    mode_d = accept_mode;
                    unique case (accept_mode)
                        MODE_WAIT:   state_d = ST_WAIT;
                        MODE_DOZE:   state_d = ST_DOZE;
                        MODE_RETAIN: state_d = ST_RETAIN;
                        MODE_DSLEEP: state_d = ST_DSLEEP;
                        MODE_HIBER:  state_d = ST_HIBER;
                        default:     state_d = ST_RUN;
                    endcase
                end
            end
            ST_WAIT, ST_DOZE: begin
                if (irq) begin
                    state_d = ST_RUN;
                    mode_d  = MODE_RUN;
                end
            end
            ST_RETAIN, ST_DSLEEP: begin
                if (irq) state_d = ST_RELOCK;
            end
            ST_RELOCK: begin
                if (relock_ready) state_d = ST_SREXIT;
            end
            ST_SREXIT: begin
                state_d = ST_RUN;
                mode_d  = MODE_RUN;
            end
            ST_HIBER: state_d = ST_HIBER;
            default: begin
                state_d = ST_RUN;
                mode_d  = MODE_RUN;
            end
        endcase
    end

    // State and reported-mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            mode_q  <= MODE_RUN;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
        end
    end

    lpm_gate_decode #(.N_PERIPH(N_PERIPH)) u_dec (
        .state         (state_q),
        .mask          (mask_q),
        .core_clk_en   (core_clk_en),
        .bus_clk_en    (bus_clk_en),
        .periph_clk_en (periph_clk_en),
        .pll_en        (pll_en),
        .mem_sr_req    (mem_sr_req),
        .core_pwr_en   (core_pwr_en),
        .chip_pdn_req  (chip_pdn_req)
    );

    // Reported mode is the one actually reached.
    always_comb cur_mode = mode_q;

endmodule

// File: rtl/lpm_ctrl_chk.sv
// Property checker for lpm_ctrl, attached by bind.
// Does: relates the controller outputs over time. Assumes the same
// clock and synchronous active-low reset as the controller.
module lpm_ctrl_chk #(
    parameter int N_PERIPH = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                irq,
    input logic                core_clk_en,
    input logic                bus_clk_en,
    input logic [N_PERIPH-1:0] periph_clk_en,
    input logic                pll_en,
    input logic                mem_sr_req,
    input logic                core_pwr_en,
    input logic                chip_pdn_req,
    input logic [2:0]          cur_mode
);

    AST_HIBER_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == 3'd5) |=> (cur_mode == 3'd5 && chip_pdn_req)); // R9

    AST_PDN_ONLY_HIBER: assert property (@(posedge clk) disable iff (!rst_n)
        chip_pdn_req |-> (cur_mode == 3'd5 && !core_pwr_en && !pll_en)); // R9

    AST_CLK_NEEDS_PLL: assert property (@(posedge clk) disable iff (!rst_n)
        (core_clk_en || bus_clk_en) |-> (pll_en && core_pwr_en)); // R8

    AST_SR_NO_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sr_req |-> (!bus_clk_en && !core_clk_en && periph_clk_en == '0)); // R5

    AST_PWR_OFF_NO_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        !core_pwr_en |-> (!core_clk_en && !bus_clk_en && !pll_en)); // R6

    AST_SR_CLEAR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_clk_en) |-> !$past(mem_sr_req)); // R8

    AST_RUN_FULL_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == 3'd0) |-> (core_clk_en && bus_clk_en && (&periph_clk_en)
                                && pll_en && core_pwr_en && !mem_sr_req)); // R10

    AST_NO_SLEEP_HOP: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode != 3'd0) |=> (cur_mode == 3'd0 || $stable(cur_mode))); // R2

    AST_RUN_IRQ_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == 3'd0 && irq) |=> (cur_mode != 3'd0 || core_clk_en)); // R7

endmodule

bind lpm_ctrl lpm_ctrl_chk #(.N_PERIPH(N_PERIPH)) u_lpm_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .irq           (irq),
    .core_clk_en   (core_clk_en),
    .bus_clk_en    (bus_clk_en),
    .periph_clk_en (periph_clk_en),
    .pll_en        (pll_en),
    .mem_sr_req    (mem_sr_req),
    .core_pwr_en   (core_pwr_en),
    .chip_pdn_req  (chip_pdn_req),
    .cur_mode      (cur_mode)
);

// File: tb/tb_lpm_ctrl.sv
// Scoreboard bench for lpm_ctrl: the driver queues the expected output
// pattern of each mode entry; a monitor pops and compares on every
// reported mode change. Direct checks cover ignored stimuli and wake timing.
module tb_lpm_ctrl;

    localparam int NP     = 8;
    localparam int RELOCK = 4;

    typedef struct packed {
        logic [2:0]    mode;
        logic          core;
        logic          bus;
        logic [NP-1:0] per;
        logic          pll;
        logic          sr;
        logic          pwr;
        logic          pdn;
    } obs_s;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [2:0]    req_mode = 3'd0;
    logic          mask_wr = 1'b0;
    logic [NP-1:0] mask_in = '0;
    logic          irq = 1'b0;
    logic          pll_locked = 1'b1;
    logic          core_clk_en, bus_clk_en, pll_en, mem_sr_req, core_pwr_en, chip_pdn_req;
    logic [NP-1:0] periph_clk_en;
    logic [2:0]    cur_mode;

    int n_checks = 0;
    int n_fail   = 0;
    logic [NP-1:0] mask_model = '0;
    logic [2:0]    prev_mode = 3'd0;
    obs_s          exp_q[$];
    string         tag_q[$];

    lpm_ctrl #(.N_PERIPH(NP), .RELOCK_MIN(RELOCK)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .mask_wr(mask_wr), .mask_in(mask_in), .irq(irq), .pll_locked(pll_locked),
        .core_clk_en(core_clk_en), .bus_clk_en(bus_clk_en), .periph_clk_en(periph_clk_en),
        .pll_en(pll_en), .mem_sr_req(mem_sr_req), .core_pwr_en(core_pwr_en),
        .chip_pdn_req(chip_pdn_req), .cur_mode(cur_mode)
    );

    always #5 clk = ~clk;

    obs_s obs;
    always_comb obs = '{mode:cur_mode, core:core_clk_en, bus:bus_clk_en, per:periph_clk_en,
                        pll:pll_en, sr:mem_sr_req, pwr:core_pwr_en, pdn:chip_pdn_req};

    // Expected pattern per mode, from the requirements.
    function automatic obs_s exp_for(logic [2:0] m, logic [NP-1:0] msk);
        obs_s e;
        e = '{mode:m, core:1'b0, bus:1'b0, per:'0, pll:1'b0, sr:1'b0, pwr:1'b0, pdn:1'b0};
        case (m)
            3'd0: begin e.core = 1'b1; e.bus = 1'b1; e.per = '1; e.pll = 1'b1; e.pwr = 1'b1; end
            3'd1: begin e.bus = 1'b1; e.per = '1; e.pll = 1'b1; e.pwr = 1'b1; end
            3'd2: begin e.per = ~msk; e.pll = 1'b1; e.pwr = 1'b1; end
            3'd3: begin e.sr = 1'b1; e.pwr = 1'b1; end
            3'd4: begin e.sr = 1'b1; end
            default: begin e.pdn = 1'b1; end
        endcase
        return e;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(logic [2:0] m, string tag);
        exp_q.push_back(exp_for(m, mask_model));
        tag_q.push_back(tag);
    endtask

    task automatic send_req(logic [2:0] m);
        req_valid = 1'b1;
        req_mode  = m;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic pulse_irq();
        irq = 1'b1;
        @(negedge clk);
        irq = 1'b0;
    endtask

    task automatic write_mask(logic [NP-1:0] v, bool_upd);
        mask_wr = 1'b1;
        mask_in = v;
        @(negedge clk);
        mask_wr = 1'b0;
        if (bool_upd) mask_model = v;
    endtask

    // Monitor: compares every reported mode change with the queue head.
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_mode <= 3'd0;
        end else if (cur_mode != prev_mode) begin
            if (exp_q.size() == 0) begin
                chk("R10 unexpected mode change", {29'd0, cur_mode}, {29'd0, prev_mode});
            end else begin
                obs_s e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, 32'(obs), 32'(e));
            end
            prev_mode <= cur_mode;
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 outputs during reset", 32'(obs), 32'(exp_for(3'd0, '0)));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 state after reset", 32'(obs), 32'(exp_for(3'd0, '0)));

        // Wait mode, ignored request inside it, interrupt wake.
        write_mask(8'hA5, 1'b1);
        push(3'd1, "R3 wait pattern");
        send_req(3'd1);
        send_req(3'd2);
        repeat (2) @(negedge clk);
        chk("R2 request outside run ignored", {29'd0, cur_mode}, 32'd1);
        push(3'd0, "R7 wake from wait");
        pulse_irq();
        chk("R7 run after wait irq", {29'd0, cur_mode}, 32'd0);

        // Interrupt in run and illegal codes.
        pulse_irq();
        @(negedge clk);
        chk("R7 irq in run no effect", 32'(obs), 32'(exp_for(3'd0, mask_model)));
        send_req(3'd6);
        send_req(3'd7);
        send_req(3'd0);
        @(negedge clk);
        chk("R2 illegal codes ignored", {29'd0, cur_mode}, 32'd0);

        // Doze with mask; write inside doze ignored.
        push(3'd2, "R4 doze mask A5");
        send_req(3'd2);
        write_mask(8'h0F, 1'b0);
        push(3'd0, "R7 wake from doze");
        pulse_irq();
        push(3'd2, "R4 mask write in doze ignored");
        send_req(3'd2);
        push(3'd0, "R7 wake from doze again");
        pulse_irq();
        write_mask(8'h3C, 1'b1);
        push(3'd2, "R4 doze mask 3C");
        send_req(3'd2);
        push(3'd0, "R7 wake third doze");
        pulse_irq();

        // Retention; wake with lock held low.
        push(3'd3, "R5 retention pattern");
        send_req(3'd3);
        pll_locked = 1'b0;
        repeat (2) @(negedge clk);
        pulse_irq();
        chk("R8 relock step pll and power on",
            {25'd0, cur_mode, pll_en, core_pwr_en, mem_sr_req, core_clk_en},
            {25'd0, 3'd3, 1'b1, 1'b1, 1'b1, 1'b0});
        repeat (10) @(negedge clk);
        chk("R8 no run without lock", {28'd0, cur_mode, core_clk_en}, {28'd0, 3'd3, 1'b0});
        push(3'd0, "R8 run after retention wake");
        pll_locked = 1'b1;
        @(negedge clk);
        chk("R8 self-refresh cleared before clocks",
            {27'd0, cur_mode, mem_sr_req, core_clk_en}, {27'd0, 3'd3, 1'b0, 1'b0});
        @(negedge clk);
        chk("R8 run reached after exit step", {29'd0, cur_mode}, 32'd0);

        // Deep sleep with a stale lock indication.
        push(3'd4, "R6 deep sleep pattern");
        send_req(3'd4);
        @(negedge clk);
        push(3'd0, "R8 run after deep sleep wake");
        pulse_irq();
        chk("R8 core power back during relock", {31'd0, core_pwr_en}, 32'd1);
        for (int k = 0; k < RELOCK + 1; k++) begin
            @(negedge clk);
            chk("R8 settle window honoured", {28'd0, cur_mode, core_clk_en}, {28'd0, 3'd4, 1'b0});
        end
        chk("R8 exit step before run", {31'd0, mem_sr_req}, 32'd0);
        @(negedge clk);
        chk("R10 run after deep sleep", {29'd0, cur_mode}, 32'd0);

        // Hibernate: interrupts and requests ignored, reset leaves.
        push(3'd5, "R9 hibernate pattern");
        send_req(3'd5);
        pulse_irq();
        send_req(3'd1);
        repeat (3) @(negedge clk);
        chk("R9 hibernate holds", 32'(obs), 32'(exp_for(3'd5, mask_model)));
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        mask_model = '0;
        @(negedge clk);
        chk("R9 reset leaves hibernate", 32'(obs), 32'(exp_for(3'd0, '0)));
        push(3'd2, "R1 mask cleared by reset");
        send_req(3'd2);
        push(3'd0, "R7 final wake");
        pulse_irq();
        @(negedge clk);
        chk("R10 all expected transitions seen", exp_q.size(), 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule